// File: doc/BRIEF.md
# Broken-Array Approximate Unsigned Multiplier

This block multiplies two unsigned operands in a single combinational pass and returns an approximate double-width product. Its core is a carry-save array. Rows of AND-gate partial products are folded through layers of half and full adders. A carry-propagate adder then merges the sum and carry vectors that remain after the last layer.

Two elaboration-time cut parameters trade accuracy for area by removing array cells. The row cut `HC` deletes every multiplier row whose index lies below it. The column cut `VC` deletes every partial product whose weight `i + j` lies below it. Any adder left with nothing to add is not built. With both cuts at zero, the array is an exact multiplier.

Legal settings satisfy `0 <= HC < N` and `HC <= VC < 2N`. Elaboration stops with an error for any other combination. The block has no clock and no state. The product is valid once the inputs have propagated through the logic.

Top module: `brokenArrayMul`

## Requirements
- R1: With `HC = 0` and `VC = 0`, `p` equals the exact unsigned product `a * b` for every operand pair.
- R2: Rows with multiplier index below `HC` contribute nothing. When `b < 2^HC`, `p` is 0.
- R3: For every operand pair, `p` equals the sum of `a[i]*b[j]*2^(i+j)` over the cells with `j >= HC` and `i + j >= VC`. This holds for every legal `(HC, VC)` pair.
- R4: Product bits with an index below `max(HC, VC)` are always 0.
- R5: With `VC = 2N-1`, `p` is 0 for all operands.
- R6: `p` never exceeds the exact product `a * b`.
- R7: With both operands at all ones, the carries ripple through the full upper half of the product. The result still matches the R3 sum, and with no cuts it equals `(2^N-1)^2`.
- R8: A zero operand on either input gives `p = 0`, in the same cycle as the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned; bit j selects array row j |
| p | output | 2N | Approximate product |

## Verification
Two effects can shape the same output bits for one operand pair. The first is the forcing of low bits to zero below the cut. The second is the final adder's carry chain, which draws on columns just above the cut. Exhaustive operand sweeps provoke both at once: all 4096 pairs at width six, and all 256 pairs at width four across every legal cut pair. The all-ones operands give the longest carry. Each result is judged against a bench model that sums only the kept cells. The same result is also checked for zero bits below the cut and for never exceeding the exact product.

// File: rtl/bamPkg.sv
package bamPkg;

  localparam int MAX_W = 64;

  typedef logic [MAX_W-1:0] colMask_t;

  // Columns that hold a kept partial product in row j.
  function automatic colMask_t ppMask(int n, int hc, int vc, int j);
    colMask_t m = '0;
    for (int k = 0; k < 2*n; k++) begin
      if ((j >= hc) && (k - j >= 0) && (k - j < n) && (k >= vc)) m[k] = 1'b1;
    end
    return m;
  endfunction

  // Columns that carry a live sum (wantCarry = 0) or carry (wantCarry = 1)
  // after adder row j has been applied.
  function automatic colMask_t stateMask(int n, int hc, int vc, int j, bit wantCarry);
    colMask_t s, c, ns, nc, pm;
    int cnt;
    s = ppMask(n, hc, vc, hc);
    c = '0;
    for (int r = hc + 1; r <= j; r++) begin
      pm = ppMask(n, hc, vc, r);
      ns = '0;
      nc = '0;
      for (int k = 0; k < 2*n; k++) begin
        cnt = int'(pm[k]) + int'(s[k]) + int'(c[k]);
        if (cnt >= 1) ns[k] = 1'b1;
        if ((cnt >= 2) && (k + 1 < 2*n)) nc[k+1] = 1'b1;
      end
      s = ns;
      c = nc;
    end
    return wantCarry ? c : s;
  endfunction

  function automatic int lowestSet(colMask_t m, int w);
    for (int k = 0; k < w; k++) begin
      if (m[k]) return k;
    end
    return w;
  endfunction

endpackage

// File: rtl/bamPartialProducts.sv
module bamPartialProducts #(
  parameter int N  = 8,
  parameter int HC = 0,
  parameter int VC = 0
) (
  input  logic [N-1:0]            a,
  input  logic [N-1:0]            b,
  output logic [N-1:0][2*N-1:0]   ppRows
);
  localparam int W = 2 * N;

  for (genvar j = 0; j < N; j++) begin : g_row
    localparam bamPkg::colMask_t ROW_M = bamPkg::ppMask(N, HC, VC, j);
    for (genvar k = 0; k < W; k++) begin : g_col
      if (ROW_M[k]) begin : g_and
        assign ppRows[j][k] = a[k-j] & b[j];
      end else begin : g_cut
        assign ppRows[j][k] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/bamCsaRow.sv
module bamCsaRow #(
  parameter int               W    = 16,
  parameter bamPkg::colMask_t PP_M = '0,
  parameter bamPkg::colMask_t S_M  = '0,
  parameter bamPkg::colMask_t C_M  = '0
) (
  input  logic [W-1:0] ppIn,
  input  logic [W-1:0] sumIn,
  input  logic [W-1:0] carIn,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carOut
);
  logic [W:0] cy;

  assign cy[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_cell
    localparam int CNT = int'(PP_M[k]) + int'(S_M[k]) + int'(C_M[k]);
    if (CNT == 3) begin : g_fa
      assign sumOut[k] = ppIn[k] ^ sumIn[k] ^ carIn[k];
      assign cy[k+1]   = (ppIn[k] & sumIn[k]) | (ppIn[k] & carIn[k]) | (sumIn[k] & carIn[k]);
    end else if (CNT == 2) begin : g_ha
      logic hx, hy;
      assign hx        = PP_M[k] ? ppIn[k]  : sumIn[k];
      assign hy        = C_M[k]  ? carIn[k] : sumIn[k];
      assign sumOut[k] = hx ^ hy;
      assign cy[k+1]   = hx & hy;
    end else if (CNT == 1) begin : g_wire
      assign sumOut[k] = PP_M[k] ? ppIn[k] : (S_M[k] ? sumIn[k] : carIn[k]);
      assign cy[k+1]   = 1'b0;
    end else begin : g_empty
      assign sumOut[k] = 1'b0;
      assign cy[k+1]   = 1'b0;
    end
  end

  assign carOut = cy[W-1:0];

  // The running sum is bounded by the full product, so nothing leaves the top column.
  always_comb begin : chkTop
    p_top_carry_zero_r3: assert (cy[W] == 1'b0);
  end

endmodule

// File: rtl/bamMergeAdder.sv
module bamMergeAdder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] cc;

  assign cc[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign sum[k]  = x[k] ^ y[k] ^ cc[k];
    assign cc[k+1] = (x[k] & y[k]) | (x[k] & cc[k]) | (y[k] & cc[k]);
  end

  assign cout = cc[W];

endmodule

// File: rtl/brokenArrayMul.sv
module brokenArrayMul #(
  parameter int N  = 8,
  parameter int HC = 2,
  parameter int VC = 6
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int W      = 2 * N;
  localparam int ROWS   = N - HC;
  localparam int LOWZ   = (HC > VC) ? HC : VC;
  localparam bit KILL   = (VC == W - 1);
  localparam bamPkg::colMask_t C_FIN = bamPkg::stateMask(N, HC, VC, N - 1, 1'b1);
  localparam int CPA_LO = bamPkg::lowestSet(C_FIN, W);
  localparam logic [W-1:0] KEEP_OUT = KILL ? '0 : ({W{1'b1}} << LOWZ);

  if (!((HC >= 0) && (HC < N) && (VC >= HC) && (VC < W) && (W <= bamPkg::MAX_W))) begin : g_badCut
    $error("brokenArrayMul: illegal cut setting");
  end

  logic [N-1:0][W-1:0] ppRows;
  logic [W-1:0]        sumVec [ROWS];
  logic [W-1:0]        carVec [ROWS];
  logic [W-1:0]        rawProd;
  logic                cpaCout;

  bamPartialProducts #(.N(N), .HC(HC), .VC(VC)) i_ppPlane (
    .a      (a),
    .b      (b),
    .ppRows (ppRows)
  );

  assign sumVec[0] = ppRows[HC];
  assign carVec[0] = '0;

  for (genvar j = HC + 1; j < N; j++) begin : g_adderRow
    bamCsaRow #(
      .W    (W),
      .PP_M (bamPkg::ppMask(N, HC, VC, j)),
      .S_M  (bamPkg::stateMask(N, HC, VC, j - 1, 1'b0)),
      .C_M  (bamPkg::stateMask(N, HC, VC, j - 1, 1'b1))
    ) i_csaRow (
      .ppIn   (ppRows[j]),
      .sumIn  (sumVec[j-HC-1]),
      .carIn  (carVec[j-HC-1]),
      .sumOut (sumVec[j-HC]),
      .carOut (carVec[j-HC])
    );
  end

  if (CPA_LO >= W) begin : g_noMerge
    assign rawProd = sumVec[ROWS-1];
    assign cpaCout = 1'b0;
  end else begin : g_merge
    if (CPA_LO > 0) begin : g_lowPass
      assign rawProd[CPA_LO-1:0] = sumVec[ROWS-1][CPA_LO-1:0];
    end
    bamMergeAdder #(.W(W - CPA_LO)) i_mergeAdder (
      .x    (sumVec[ROWS-1][W-1:CPA_LO]),
      .y    (carVec[ROWS-1][W-1:CPA_LO]),
      .sum  (rawProd[W-1:CPA_LO]),
      .cout (cpaCout)
    );
  end

  assign p = rawProd & KEEP_OUT;

  logic [W-1:0] exactProd;
  assign exactProd = W'(a) * W'(b);

  always_comb begin : chkArith
    p_below_exact_r6:   assert (p <= exactProd);
    p_low_rows_r2:      assert (((W'(b) >> HC) != '0) || (p == '0));
    p_merge_no_cout_r3: assert (cpaCout == 1'b0);
  end

  if (LOWZ > 0) begin : g_chkLow
    always_comb begin : chkLow
      p_low_zero_r4: assert (rawProd[LOWZ-1:0] == '0);
    end
  end

  if ((HC == 0) && (VC == 0)) begin : g_chkExact
    always_comb begin : chkExact
      p_exact_r1: assert (p == exactProd);
    end
  end

  if (KILL) begin : g_chkKill
    always_comb begin : chkKill
      p_kill_r5: assert (rawProd == '0);
    end
  end

endmodule

// File: tb/test_brokenArrayMul.sv
module test_brokenArrayMul;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 6;
  localparam int HM = 1;
  localparam int VM = 4;
  localparam int NG = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  logic [NM-1:0]   aM, bM;
  logic [2*NM-1:0] pM, pExact;
  logic [NG-1:0]   aG, bG;
  logic [2*NG-1:0] pGrid [NG][2*NG];

  brokenArrayMul #(.N(NM), .HC(HM), .VC(VM)) i_brokenArrayMul (.a(aM), .b(bM), .p(pM));
  brokenArrayMul #(.N(NM), .HC(0), .VC(0))   i_exactMul       (.a(aM), .b(bM), .p(pExact));

  for (genvar gh = 0; gh < NG; gh++) begin : g_hc
    for (genvar gv = 0; gv < 2*NG; gv++) begin : g_vc
      if (gv >= gh) begin : g_dut
        brokenArrayMul #(.N(NG), .HC(gh), .VC(gv)) i_brokenArrayMul (.a(aG), .b(bG), .p(pGrid[gh][gv]));
      end else begin : g_none
        assign pGrid[gh][gv] = '0;
      end
    end
  end

  function automatic longint refProd(int n, int hc, int vc, longint x, longint y);
    longint s = 0;
    for (int j = 0; j < n; j++) begin
      for (int i = 0; i < n; i++) begin
        if ((j >= hc) && (i + j >= vc) && x[i] && y[j]) s += longint'(1) << (i + j);
      end
    end
    return s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic applyMain(int x, int y);
    @(posedge clk);
    aM = NM'(x);
    bM = NM'(y);
    @(negedge clk);
  endtask

  // R8: zero inputs right after start
  task automatic testIdle();
    applyMain(0, 0);
    check(pM == '0, "R8 idle", pM, 0);
    check(pExact == '0, "R8 idle exact", pExact, 0);
  endtask

  // R1 R3 R4 R6: every operand pair at width six
  task automatic testMainExhaustive();
    for (int x = 0; x < (1 << NM); x++) begin
      for (int y = 0; y < (1 << NM); y++) begin
        applyMain(x, y);
        check(longint'(pM) == refProd(NM, HM, VM, x, y), "R3 kept-cell sum", pM, refProd(NM, HM, VM, x, y));
        check(pM[VM-1:0] == '0, "R4 low bits", pM[VM-1:0], 0);
        check(longint'(pM) <= longint'(x * y), "R6 not above exact", pM, x * y);
        check(longint'(pExact) == longint'(x * y), "R1 exact product", pExact, x * y);
      end
    end
  endtask

  // R2: multiplier confined to the removed rows
  task automatic testLowRows();
    for (int x = 0; x < (1 << NM); x++) begin
      for (int y = 0; y < (1 << HM); y++) begin
        applyMain(x, y);
        check(pM == '0, "R2 removed rows", pM, 0);
      end
    end
  endtask

  // R8: a zero operand on either side
  task automatic testZeroOperand();
    for (int v = 0; v < (1 << NM); v++) begin
      applyMain(0, v);
      check(pM == '0 && pExact == '0, "R8 zero multiplicand", pM, 0);
      applyMain(v, 0);
      check(pM == '0 && pExact == '0, "R8 zero multiplier", pM, 0);
    end
  endtask

  // R7: longest carry chain
  task automatic testAllOnes();
    applyMain((1 << NM) - 1, (1 << NM) - 1);
    check(longint'(pM) == refProd(NM, HM, VM, 63, 63), "R7 all ones cut", pM, refProd(NM, HM, VM, 63, 63));
    check(longint'(pExact) == 3969, "R7 all ones exact", pExact, 3969);
  endtask

  // R3 R5 R4: every legal cut pair at width four
  task automatic testGrid();
    for (int x = 0; x < (1 << NG); x++) begin
      for (int y = 0; y < (1 << NG); y++) begin
        @(posedge clk);
        aG = NG'(x);
        bG = NG'(y);
        @(negedge clk);
        for (int h = 0; h < NG; h++) begin
          for (int v = h; v < 2*NG; v++) begin
            check(longint'(pGrid[h][v]) == refProd(NG, h, v, x, y), "R3 grid", pGrid[h][v], refProd(NG, h, v, x, y));
            check((longint'(pGrid[h][v]) & ((longint'(1) << v) - 1)) == 0, "R4 grid low bits", pGrid[h][v], 0);
            if (v == 2*NG - 1) check(pGrid[h][v] == '0, "R5 full column cut", pGrid[h][v], 0);
          end
        end
      end
    end
  endtask

  initial begin
    aM = '0; bM = '0; aG = '0; bG = '0;
    testIdle();
    testMainExhaustive();
    testLowRows();
    testZeroOperand();
    testAllOnes();
    testGrid();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

endmodule